// File: doc/BRIEF.md
# Watchdog Timer with Sleep Wake

This block supervises software by counting ticks of a slow, always-running low-power clock. Software must strobe a clear input often enough to keep the count from reaching a terminal stage. A 5-bit select field sets that stage on a 25-bit counter, so the time-out is a power of two in ticks. When the count does reach the terminal stage, the action depends on the power state. While the system runs normally, the block pulses a device reset request. While the system sits in a sleep or idle state, it pulses a wake-up non-maskable interrupt instead.

The watchdog turns on when a configuration enable or a software enable is high. Turning it off zeroes the count. A separate power-up delay counts a fixed number of low-power ticks after reset, then raises a ready output. Both parts run on the main clock `clk`. The low-power clock reaches them only as a one-cycle enable, `lp_tick`.

The control state machine has four states. `WD_OFF` means disabled. `WD_RUN` means counting. `WD_BITE` is a one-cycle reset pulse, and `WD_WAKE` is a one-cycle wake pulse. Its transitions are:
- OFF->RUN (enable high)
- RUN->OFF (enable low)
- RUN->BITE (terminal tick, no clear, power-save low)
- RUN->WAKE (terminal tick, no clear, power-save high)
- BITE/WAKE->RUN (enable still high)
- BITE/WAKE->OFF (enable low)

The power-up delay has two states, `PU_WAIT` and `PU_DONE`, and a single transition: WAIT->DONE on the last tick of the delay.

Top module: `wdt_sleepwake`

## Requirements
- R1: The count advances only on a cycle with `lp_tick` high while `cfg_en` or `sw_en` is high. Either enable alone is sufficient. Ticks seen while both enables are low never produce `rst_req` or `wake_nmi`.
- R2: With s = `ps_sel` and s <= CNT_W-1, expiry happens on the 2^s-th tick after counting starts from zero. The pulse appears in the cycle after that tick's clock edge.
- R3: Any `ps_sel` value above CNT_W-1 behaves as stage CNT_W-1, which gives a period of 2^(CNT_W-1) ticks.
- R4: A high `clr` zeroes the count. When `clr` falls in the same cycle as the terminal tick, the clear wins: no pulse is produced, and a full period follows.
- R5: An expiry with `pwr_save` low produces `rst_req` for exactly one cycle, and `wake_nmi` stays low.
- R6: An expiry with `pwr_save` high produces `wake_nmi` for exactly one cycle, and `rst_req` stays low.
- R7: After either pulse the count restarts from zero, so the next expiry again takes a full period.
- R8: Dropping both enables zeroes the count. Enabling again gives a full period before expiry.
- R9: With `pwrt_en` high, `pwrup_ready` is low from reset until PWRUP_TICKS ticks have been counted. It rises in the cycle after the last of those ticks and then stays high.
- R10: With `pwrt_en` low, `pwrup_ready` is high as soon as reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lp_tick | input | 1 | One-cycle enable marking a low-power clock tick |
| cfg_en | input | 1 | Watchdog enable from configuration |
| sw_en | input | 1 | Watchdog enable from software |
| clr | input | 1 | Clear strobe that zeroes the count |
| pwr_save | input | 1 | High while the system is in sleep or idle |
| ps_sel | input | SEL_W (5) | Postscaler stage select |
| pwrt_en | input | 1 | Enables the power-up delay |
| rst_req | output | 1 | One-cycle device reset request |
| wake_nmi | output | 1 | One-cycle wake non-maskable interrupt |
| pwrup_ready | output | 1 | High once the power-up delay has elapsed |

## Verification
The clear strobe and the terminal tick can arrive in the same clock cycle. In that case the design must choose between clearing the count and signalling expiry. The bench provokes this by counting to one tick short of the period, then driving `clr` and `lp_tick` together on a single cycle. The result is judged correct if neither pulse appears in the following cycle and the next expiry takes a full period of ticks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_BITE = 2'd2,
        WD_WAKE = 2'd3
    } wd_state_e;

    typedef enum logic {
        PU_WAIT = 1'b0,
        PU_DONE = 1'b1
    } pu_state_e;

endpackage

// File: rtl/wdt_stage_cnt.sv
module wdt_stage_cnt #(
    parameter int CNT_W = 25,
    parameter int SEL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             adv,
    input  logic [SEL_W-1:0] sel,
    output logic             terminal
);
    localparam int TOP_STAGE = CNT_W - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    int               stage_i;

    // R3: clamp the select to the top stage
    always_comb begin
        if (int'(sel) > TOP_STAGE) stage_i = TOP_STAGE;
        else                       stage_i = int'(sel);
    end

    // R2: period 2^stage -> terminal value 2^stage - 1
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            limit[i] = (i < stage_i);
        end
    end

    assign terminal = (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (hold)     cnt_q <= '0;
        else if (adv)      cnt_q <= terminal ? '0 : cnt_q + 1'b1;
    end

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !hold && !terminal) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R1
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !hold) |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_ctrl_fsm.sv
module wdt_ctrl_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic tick,
    input  logic terminal,
    input  logic pwr_save,
    output logic cnt_hold,
    output logic rst_req,
    output logic wake_nmi
);
    wd_state_e state_q, state_d;
    logic      expire;

    // R4: a clear in the terminal cycle suppresses expiry
    assign expire = en && tick && terminal && !clr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:  if (en) state_d = WD_RUN;
            WD_RUN: begin
                if (!en)         state_d = WD_OFF;
                else if (expire) state_d = pwr_save ? WD_WAKE : WD_BITE;
            end
            WD_BITE: state_d = en ? WD_RUN : WD_OFF;
            WD_WAKE: state_d = en ? WD_RUN : WD_OFF;
            default: state_d = WD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        rst_req  = (state_q == WD_BITE);
        wake_nmi = (state_q == WD_WAKE);
        // R7, R8: counter is zeroed outside RUN, when disabled, or on clear
        cnt_hold = (state_q != WD_RUN) || !en || clr;
    end

    // R5, R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && wake_nmi));

    // R5
    bite_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(pwr_save));

    // R6
    wake_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_nmi |-> $past(pwr_save));

    // R5
    bite_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R6
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_nmi |=> !wake_nmi);

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(rst_req || wake_nmi));

endmodule

// File: rtl/pwrup_delay.sv
module pwrup_delay
    import wdt_pkg::*;
#(
    parameter int PWRUP_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pwrt_en,
    output logic ready
);
    localparam int CW = $clog2(PWRUP_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(PWRUP_TICKS - 1);

    pu_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PU_WAIT: if (tick && cnt_q == LAST) state_d = PU_DONE;
            PU_DONE: state_d = PU_DONE;
            default: state_d = PU_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PU_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == PU_WAIT && tick && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9, R10
    always_comb ready = (state_q == PU_DONE) || !pwrt_en;

    // R9
    pu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PU_DONE) |=> (state_q == PU_DONE));

    // R9
    pu_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/wdt_sleepwake.sv
module wdt_sleepwake #(
    parameter int CNT_W       = 25,
    parameter int SEL_W       = 5,
    parameter int PWRUP_TICKS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lp_tick,
    input  logic             cfg_en,
    input  logic             sw_en,
    input  logic             clr,
    input  logic             pwr_save,
    input  logic [SEL_W-1:0] ps_sel,
    input  logic             pwrt_en,
    output logic             rst_req,
    output logic             wake_nmi,
    output logic             pwrup_ready
);
    logic wd_en;
    logic cnt_hold;
    logic terminal;

    // R1: either enable source turns the watchdog on
    assign wd_en = cfg_en | sw_en;

    wdt_stage_cnt #(
        .CNT_W (CNT_W),
        .SEL_W (SEL_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (cnt_hold),
        .adv      (lp_tick),
        .sel      (ps_sel),
        .terminal (terminal)
    );

    wdt_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (wd_en),
        .clr      (clr),
        .tick     (lp_tick),
        .terminal (terminal),
        .pwr_save (pwr_save),
        .cnt_hold (cnt_hold),
        .rst_req  (rst_req),
        .wake_nmi (wake_nmi)
    );

    pwrup_delay #(
        .PWRUP_TICKS (PWRUP_TICKS)
    ) u_pu (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (lp_tick),
        .pwrt_en (pwrt_en),
        .ready   (pwrup_ready)
    );

endmodule

// File: tb/sim_wdt_sleepwake.sv
module sim_wdt_sleepwake;
    localparam int CNT_W = 6;
    localparam int SEL_W = 5;
    localparam int PU_T  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp_tick = 1'b0, cfg_en = 1'b0, sw_en = 1'b0, clr = 1'b0;
    logic pwr_save = 1'b0, pwrt_en = 1'b1;
    logic [SEL_W-1:0] ps_sel = '0;
    logic rst_req, wake_nmi, pwrup_ready;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    wdt_sleepwake #(.CNT_W(CNT_W), .SEL_W(SEL_W), .PWRUP_TICKS(PU_T)) u0 (
        .clk(clk), .rst_n(rst_n), .lp_tick(lp_tick), .cfg_en(cfg_en), .sw_en(sw_en),
        .clr(clr), .pwr_save(pwr_save), .ps_sel(ps_sel), .pwrt_en(pwrt_en),
        .rst_req(rst_req), .wake_nmi(wake_nmi), .pwrup_ready(pwrup_ready)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge after the tick edge
    task automatic tick();
        lp_tick = 1'b1;
        @(negedge clk);
        lp_tick = 1'b0;
    endtask

    task automatic measure(output int n, output logic r, output logic w);
        n = 0; r = 1'b0; w = 1'b0;
        for (int i = 0; i < 200; i++) begin
            tick();
            n++;
            if (rst_req || wake_nmi) begin
                r = rst_req; w = wake_nmi;
                break;
            end
        end
    endtask

    task automatic do_reset(input logic pe);
        pwrt_en = pe;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n, exp, stg;
        logic r, w;

        do_reset(1'b1);
        check(!rst_req && !wake_nmi, "R5 reset outputs", int'(rst_req | wake_nmi), 0);
        check(!pwrup_ready, "R9 ready low at reset", int'(pwrup_ready), 0);

        // R9: power-up delay
        for (int k = 1; k <= PU_T; k++) begin
            tick();
            check(pwrup_ready == (k == PU_T), "R9 power-up ready", int'(pwrup_ready), int'(k == PU_T));
        end
        repeat (3) tick();
        check(pwrup_ready, "R9 ready stays high", int'(pwrup_ready), 1);

        // R1: ticks while disabled do nothing
        ps_sel = '0;
        for (int k = 0; k < 10; k++) begin
            tick();
            check(!rst_req && !wake_nmi, "R1 disabled ticks ignored", int'(rst_req | wake_nmi), 0);
        end

        // R2, R3, R5, R6, R7: sweep select and power state
        for (int s = 0; s < 8; s++) begin
            for (int p = 0; p < 2; p++) begin
                ps_sel = SEL_W'(s);
                pwr_save = p[0];
                if (s % 2 == 1) sw_en = 1'b1; else cfg_en = 1'b1;
                @(negedge clk);
                stg = (s > CNT_W - 1) ? CNT_W - 1 : s;
                exp = 1 << stg;
                measure(n, r, w);
                if (s > CNT_W - 1) check(n == exp, "R3 saturated period", n, exp);
                else               check(n == exp, "R2 period", n, exp);
                if (p == 0) check(r && !w, "R5 reset on running expiry", int'({r, w}), 2);
                else        check(!r && w, "R6 wake on power-save expiry", int'({r, w}), 1);
                @(negedge clk);
                check(!rst_req && !wake_nmi, "R5 R6 single-cycle pulse", int'(rst_req | wake_nmi), 0);
                measure(n, r, w);
                check(n == exp, "R7 restart full period", n, exp);
                @(negedge clk);
                cfg_en = 1'b0; sw_en = 1'b0;
                @(negedge clk);
            end
        end
        pwr_save = 1'b0;

        // R8: disable clears count
        ps_sel = 5'd3;
        cfg_en = 1'b1;
        @(negedge clk);
        repeat (5) tick();
        cfg_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        cfg_en = 1'b1;
        @(negedge clk);
        measure(n, r, w);
        check(n == 8 && r, "R8 full period after re-enable", n, 8);
        @(negedge clk);

        // R4: plain clear
        ps_sel = 5'd2;
        repeat (2) tick();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        measure(n, r, w);
        check(n == 4, "R4 clear restarts period", n, 4);
        @(negedge clk);

        // R4: clear and terminal tick in the same cycle
        repeat (3) tick();
        clr = 1'b1;
        tick();
        clr = 1'b0;
        check(!rst_req && !wake_nmi, "R4 clear beats terminal tick", int'(rst_req | wake_nmi), 0);
        measure(n, r, w);
        check(n == 4, "R4 full period after collision", n, 4);
        cfg_en = 1'b0;
        @(negedge clk);

        // R10: power-up delay bypassed
        do_reset(1'b0);
        check(pwrup_ready, "R10 ready without delay", int'(pwrup_ready), 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule